// File: doc/BRIEF.md
# DMA Command and Interrupt Control

This block is the control half of a bus-master DMA engine that moves data between a peripheral FIFO and system memory. Software writes a 32-bit command word. Only its low byte carries meaning. That byte holds a direction flag, two interrupt enables, a scatter-gather mode flag and a two-bit operation code. The block turns these writes into a small engine state: idle, active, or flushing. From that state it drives an enable and a flush request toward the datapath.

The datapath reports three conditions back to the block: FIFO empty, remaining count zero, and error. It also reports page completions. These reports set sticky status bits. Software clears a status bit by writing a one to it. The interrupt output is formed from the status bits, each gated by its enable in the command byte.

Register writes share one write port. A select line chooses between the command word (0) and the status word (1). Every write takes effect at the clock edge where `regWrEn` is sampled high. Outputs reflect the new state in the cycle after that edge.

Top module: `dma_cmd_ctrl`

## Requirements
- R1: After reset, `xferEnable`, `flushReq`, `dirToMem`, `sgMode`, `irq`, `cmdByte` and `statusBits` are all zero.
- R2: A command write (`regSel`=0) stores bits 7, 6, 5, 4, 1 and 0 of the write data into `cmdByte`. Bits 3:2 of `cmdByte` always read as zero. Bits 31:8 of the write data never affect `cmdByte`, the engine state or the status bits.
- R3: Writing operation code 11 (start) while idle makes `xferEnable` 1 in the next cycle. `dirToMem` follows command bit 7 (1 = peripheral to memory), and `sgMode` follows bit 4. A start written while active or flushing updates `cmdByte` and leaves the state unchanged.
- R4: While active, with no command write in that cycle and no error, `countZero`=1 together with `fifoEmpty`=1 returns the engine to idle and sets status bit 0 (done).
- R5: While active or flushing, with no command write in that cycle, `xferError`=1 returns the engine to idle and sets status bit 1 (error). Error takes priority over done and over the end of a drain.
- R6: Operation code 10 (abort) while active or flushing returns the engine to idle and sets status bit 2. While idle, an abort write is ignored: `cmdByte` and the status bits are unchanged.
- R7: Operation code 00 (idle) returns the engine to idle from any state. It leaves the status bits, and therefore `irq`, unchanged.
- R8: Operation code 01 (blast), written while active with the current `cmdByte` bit 7 = 1, enters the flushing state. In that state `flushReq`=1 and `xferEnable`=0. The engine stays there until `fifoEmpty`=1, then goes idle and sets status bit 3 (drain complete).
- R9: A blast written while idle, or while the current direction bit is 0, or while flushing, is ignored: `cmdByte`, the state and the status bits are unchanged.
- R10: A status write (`regSel`=1) clears each status bit whose write-data bit is 1. If a bit is set and cleared in the same cycle, setting wins.
- R11: `pageDone`=1 while active, with no command write in that cycle, sets status bit 4. `irq` = (command bit 6 AND (status bit 0 OR status bit 1)) OR (command bit 5 AND status bit 4).
- R12: When a command write and a datapath indication occur in the same cycle, the write decides the next state, and that cycle's datapath indications set no status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = command word, 1 = status word |
| regWrData | input | 32 | Write data |
| fifoEmpty | input | 1 | Peripheral FIFO holds no bytes |
| countZero | input | 1 | Remaining transfer count is zero |
| xferError | input | 1 | Datapath reports a transfer error |
| pageDone | input | 1 | One page of the transfer has completed |
| xferEnable | output | 1 | Datapath may move data (active state) |
| flushReq | output | 1 | Drain the FIFO to memory (flushing state) |
| dirToMem | output | 1 | 1 = peripheral to memory |
| sgMode | output | 1 | Scatter-gather descriptor mode enabled |
| cmdByte | output | 8 | Stored command byte |
| statusBits | output | 5 | Sticky status: 0 done, 1 error, 2 abort, 3 drain complete, 4 page |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives three corner cases.

- **Abort while idle.** A design that honoured it would raise the abort status bit without any transfer having started.
- **Blast in the memory-to-peripheral direction.** A design that accepted it would enter the flushing state, or would overwrite the held start code in `cmdByte`.
- **Collisions.** A status clear in the same cycle as a done event, and a command write in the same cycle as an error. A design with the wrong priority would lose a completion, or would drop out of a transfer that software had just re-armed.

The bench also checks that an idle command leaves the interrupt asserted, and that junk in the reserved upper bytes changes nothing.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int CMD_W   = 8;
  localparam int STAT_W  = 5;
  localparam int DIR_BIT = 7;
  localparam int IEN_BIT = 6;
  localparam int PEN_BIT = 5;
  localparam int SG_BIT  = 4;
  localparam int S_DONE  = 0;
  localparam int S_ERR   = 1;
  localparam int S_ABORT = 2;
  localparam int S_BLAST = 3;
  localparam int S_PAGE  = 4;

  // bits 3:2 of the command byte are reserved and never stored
  localparam logic [CMD_W-1:0] CMD_MASK = ~(CMD_W'(3) << 2);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_FLUSH  = 2'd2
  } engState_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_BLAST = 2'b01,
    OP_ABORT = 2'b10,
    OP_START = 2'b11
  } cmdOp_t;

  typedef struct packed {
    logic cmdLoad;
    logic setPage;
    logic setBlast;
    logic setAbort;
    logic setErr;
    logic setDone;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_reg_path.sv
module dma_reg_path
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              statWr,
  input  logic [CMD_W-1:0]  wrData,
  output logic [CMD_W-1:0]  cmdQ,
  output logic [STAT_W-1:0] statQ,
  output logic              irq
);
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;

  assign setVec[S_DONE]  = stb.setDone;
  assign setVec[S_ERR]   = stb.setErr;
  assign setVec[S_ABORT] = stb.setAbort;
  assign setVec[S_BLAST] = stb.setBlast;
  assign setVec[S_PAGE]  = stb.setPage;
  assign clrVec = statWr ? wrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdQ <= '0;
    else if (stb.cmdLoad) cmdQ <= wrData & CMD_MASK;
  end

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmdLoad |=> $stable(cmdQ));

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setDone |=> statQ[S_DONE]);

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statQ[i] <= 1'b0;
      else if (setVec[i]) statQ[i] <= 1'b1;
      else if (clrVec[i]) statQ[i] <= 1'b0;
    end

    // R10
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statWr && wrData[i] && !setVec[i]) |=> !statQ[i]);
  end

  assign irq = (cmdQ[IEN_BIT] & (statQ[S_DONE] | statQ[S_ERR]))
             | (cmdQ[PEN_BIT] & statQ[S_PAGE]);
endmodule

// File: rtl/dma_cmd_fsm.sv
module dma_cmd_fsm
  import dma_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [1:0] wrOp,
  input  logic       curDir,
  input  logic       fifoEmpty,
  input  logic       countZero,
  input  logic       xferError,
  input  logic       pagePulse,
  output ctlStrobe_t stb,
  output logic       xferEnable,
  output logic       flushReq
);
  engState_t stateQ, nextState;

  always_comb begin
    nextState = stateQ;
    stb = '0;
    if (cmdWr) begin
      unique case (wrOp)
        OP_START: begin
          stb.cmdLoad = 1'b1;
          if (stateQ == ST_IDLE) nextState = ST_ACTIVE;
        end
        OP_IDLE: begin
          stb.cmdLoad = 1'b1;
          nextState = ST_IDLE;
        end
        OP_ABORT: begin
          if (stateQ != ST_IDLE) begin
            stb.cmdLoad  = 1'b1;
            stb.setAbort = 1'b1;
            nextState    = ST_IDLE;
          end
        end
        OP_BLAST: begin
          if (stateQ == ST_ACTIVE && curDir) begin
            stb.cmdLoad = 1'b1;
            nextState   = ST_FLUSH;
          end
        end
        default: ;
      endcase
    end else begin
      unique case (stateQ)
        ST_ACTIVE: begin
          stb.setPage = pagePulse;
          if (xferError) begin
            stb.setErr = 1'b1;
            nextState  = ST_IDLE;
          end else if (countZero && fifoEmpty) begin
            stb.setDone = 1'b1;
            nextState   = ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (xferError) begin
            stb.setErr = 1'b1;
            nextState  = ST_IDLE;
          end else if (fifoEmpty) begin
            stb.setBlast = 1'b1;
            nextState    = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else stateQ <= nextState;
  end

  assign xferEnable = (stateQ == ST_ACTIVE);
  assign flushReq   = (stateQ == ST_FLUSH);

  // R3
  start_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrOp == OP_START && !xferEnable && !flushReq) |=> xferEnable);

  // R6
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrOp == OP_ABORT && !xferEnable && !flushReq) |=> (!xferEnable && !flushReq));

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !cmdWr && !xferError && !fifoEmpty) |=> flushReq);

  // R12
  wr_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrOp == OP_START && xferEnable) |=> xferEnable);
endmodule

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
  import dma_ctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              fifoEmpty,
  input  logic              countZero,
  input  logic              xferError,
  input  logic              pageDone,
  output logic              xferEnable,
  output logic              flushReq,
  output logic              dirToMem,
  output logic              sgMode,
  output logic [CMD_W-1:0]  cmdByte,
  output logic [STAT_W-1:0] statusBits,
  output logic              irq
);
  ctlStrobe_t stb;
  logic cmdWr;
  logic statWr;

  assign cmdWr  = regWrEn & ~regSel;
  assign statWr = regWrEn & regSel;

  dma_cmd_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWr      (cmdWr),
    .wrOp       (regWrData[1:0]),
    .curDir     (cmdByte[DIR_BIT]),
    .fifoEmpty  (fifoEmpty),
    .countZero  (countZero),
    .xferError  (xferError),
    .pagePulse  (pageDone),
    .stb        (stb),
    .xferEnable (xferEnable),
    .flushReq   (flushReq)
  );

  dma_reg_path u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .statWr (statWr),
    .wrData (regWrData[CMD_W-1:0]),
    .cmdQ   (cmdByte),
    .statQ  (statusBits),
    .irq    (irq)
  );

  assign dirToMem = cmdByte[DIR_BIT];
  assign sgMode   = cmdByte[SG_BIT];

  // R2
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (|regWrData[REG_W-1:CMD_W]) && regWrData[1:0] == OP_IDLE)
      |=> (!xferEnable && !flushReq));
endmodule

// File: tb/tb_dma_cmd_ctrl.sv
module tb_dma_cmd_ctrl;
  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0, regSel = 0;
  logic [31:0] regWrData = '0;
  logic fifoEmpty = 1, countZero = 0, xferError = 0, pageDone = 0;
  logic xferEnable, flushReq, dirToMem, sgMode, irq;
  logic [7:0] cmdByte;
  logic [4:0] statusBits;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 active, 2 flushing
  int mSt = 0;
  logic [7:0] mCmd = '0;
  logic [4:0] mStat = '0;

  always #2 clk = ~clk;

  dma_cmd_ctrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .fifoEmpty(fifoEmpty), .countZero(countZero),
    .xferError(xferError), .pageDone(pageDone), .xferEnable(xferEnable),
    .flushReq(flushReq), .dirToMem(dirToMem), .sgMode(sgMode),
    .cmdByte(cmdByte), .statusBits(statusBits), .irq(irq)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCmd = '0; mStat = '0;
    end else begin
      logic [4:0] setB;
      logic [4:0] clrB;
      setB = '0;
      clrB = (regWrEn && regSel) ? regWrData[4:0] : 5'h0;
      if (regWrEn && !regSel) begin
        case (regWrData[1:0])
          2'b11: begin mCmd = regWrData[7:0] & 8'hF3; if (mSt == 0) mSt = 1; end
          2'b00: begin mCmd = regWrData[7:0] & 8'hF3; mSt = 0; end
          2'b10: if (mSt != 0) begin mCmd = regWrData[7:0] & 8'hF3; mSt = 0; setB[2] = 1; end
          default: if (mSt == 1 && mCmd[7]) begin mCmd = regWrData[7:0] & 8'hF3; mSt = 2; end
        endcase
      end else if (mSt == 1) begin
        if (pageDone) setB[4] = 1;
        if (xferError) begin setB[1] = 1; mSt = 0; end
        else if (countZero && fifoEmpty) begin setB[0] = 1; mSt = 0; end
      end else if (mSt == 2) begin
        if (xferError) begin setB[1] = 1; mSt = 0; end
        else if (fifoEmpty) begin setB[3] = 1; mSt = 0; end
      end
      mStat = (mStat & ~clrB) | setB;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic mIrq;
      mIrq = (mCmd[6] & (mStat[0] | mStat[1])) | (mCmd[5] & mStat[4]);
      chk("R3", "xferEnable", xferEnable, mSt == 1);
      chk("R8", "flushReq", flushReq, mSt == 2);
      chk("R2", "cmdByte", cmdByte, mCmd);
      chk("R3", "dirToMem", dirToMem, mCmd[7]);
      chk("R3", "sgMode", sgMode, mCmd[4]);
      chk("R10", "statusBits", statusBits, mStat);
      chk("R11", "irq", irq, mIrq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wrCmd(logic [31:0] d);
    regWrEn = 1; regSel = 0; regWrData = d;
    step();
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic wrStat(logic [31:0] d);
    regWrEn = 1; regSel = 1; regWrData = d;
    step();
    regWrEn = 0; regSel = 0; regWrData = '0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "xferEnable", xferEnable, 0);
    chk("R1", "flushReq", flushReq, 0);
    chk("R1", "cmdByte", cmdByte, 0);
    chk("R1", "statusBits", statusBits, 0);
    chk("R1", "irq", irq, 0);
    rstN = 1;
    step();

    // R2/R3: reserved junk, start with all flags
    wrCmd(32'hFFFF_FFFF);
    chk("R2", "cmdByte masked", cmdByte, 8'hF3);
    chk("R3", "start active", xferEnable, 1);
    chk("R3", "dir", dirToMem, 1);
    chk("R3", "sg", sgMode, 1);

    // R11 page event
    pageDone = 1; step(); pageDone = 0;
    chk("R11", "page status", statusBits, 5'h10);
    chk("R11", "page irq", irq, 1);
    wrStat(32'h10);
    chk("R10", "cleared", statusBits, 0);

    // R4 done
    countZero = 1; step(); countZero = 0;
    chk("R4", "done idle", xferEnable, 0);
    chk("R4", "done status", statusBits, 5'h01);
    chk("R11", "done irq", irq, 1);
    wrStat(32'h1F);

    // R6 abort ignored while idle
    wrCmd(32'h42);
    chk("R6", "abort idle cmd", cmdByte, 8'hF3);
    chk("R6", "abort idle status", statusBits, 0);

    // R9 blast ignored in memory-to-peripheral direction
    wrCmd(32'h03);
    wrCmd(32'h01);
    chk("R9", "blast cmd", cmdByte, 8'h03);
    chk("R9", "blast state", xferEnable, 1);
    chk("R9", "blast flush", flushReq, 0);

    // R6 abort honoured while active
    wrCmd(32'h02);
    chk("R6", "abort idle", xferEnable, 0);
    chk("R6", "abort status", statusBits, 5'h04);
    wrStat(32'h1F);

    // R9 blast while idle ignored
    wrCmd(32'h81);
    chk("R9", "blast in idle", cmdByte, 8'h02);

    // R8 drain
    fifoEmpty = 0;
    wrCmd(32'h83);
    wrCmd(32'h81);
    chk("R8", "flushReq", flushReq, 1);
    chk("R8", "no enable", xferEnable, 0);
    step(); step();
    chk("R8", "still flushing", flushReq, 1);
    fifoEmpty = 1; step();
    chk("R8", "drain done", flushReq, 0);
    chk("R8", "drain status", statusBits, 5'h08);
    wrStat(32'h1F);

    // R5 error
    wrCmd(32'hC3);
    xferError = 1; step(); xferError = 0;
    chk("R5", "error idle", xferEnable, 0);
    chk("R5", "error status", statusBits, 5'h02);
    chk("R5", "error irq", irq, 1);
    wrStat(32'h1F);

    // R10 set wins over clear in same cycle
    wrCmd(32'hC3);
    countZero = 1; regWrEn = 1; regSel = 1; regWrData = 32'h01;
    step();
    regWrEn = 0; regSel = 0; regWrData = '0; countZero = 0;
    chk("R10", "set wins", statusBits, 5'h01);

    // R7 idle command keeps status and irq
    wrCmd(32'hC3);
    wrCmd(32'hC0);
    chk("R7", "idle state", xferEnable, 0);
    chk("R7", "idle status", statusBits, 5'h01);
    chk("R7", "idle irq", irq, 1);

    // R12 write wins over error
    wrCmd(32'hC3);
    xferError = 1; wrCmd(32'hC3); xferError = 0;
    chk("R12", "still active", xferEnable, 1);
    chk("R12", "no error bit", statusBits, 5'h01);

    // R6 abort during flush
    fifoEmpty = 0;
    wrCmd(32'hC1);
    wrCmd(32'hC2);
    chk("R6", "abort flush", flushReq, 0);
    chk("R6", "abort flush status", statusBits, 5'h05);
    fifoEmpty = 1;

    // random phase, compared each cycle by the model
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      regWrEn   = (r[3:0] < 3);
      regSel    = r[4];
      regWrData = $urandom;
      fifoEmpty = r[5] | r[6];
      countZero = (r[9:7] == 0);
      xferError = (r[14:10] == 0);
      pageDone  = (r[17:15] == 0);
      step();
    end
    regWrEn = 0; xferError = 0; pageDone = 0; countZero = 0;
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule